// File: doc/BRIEF.md
# Eight-Direction Character Outline Generator

This block colours one dot of an on-screen-display glyph cell per clock. The caller presents the glyph row that holds the current dot, together with the glyph rows directly above and below it, each 12 dots wide. It also presents the column of the dot, the character's colour and background attributes, and the trimming attributes of the text line. The block picks one of four results for the dot: the character colour, the outline (trimming) colour, the character background colour, or transparent.

A dot is an outline dot when its own glyph bit is clear and at least one of its eight surrounding dots carries a set glyph bit. A per-line policy decides whether outlines are drawn on characters that have a background. A background colour code of 0 lets the lower layer show through. The result is registered, so it appears one clock after the dot is presented. The caller supplies all-zero rows above the top row and below the bottom row of a cell.

Top module: `osd_outline_gen`

## Requirements
- R1: While reset is asserted and in the first cycles after its release, `out_vld` is 0.
- R2: A dot presented with `pix_vld` high shows its result on `out_vld`/`out_color` one clock later. A cycle with `pix_vld` low gives `out_vld` = 0 one clock later, and `out_color` keeps its previous value.
- R3: Row bit i holds column i. When bit `col` of `row_mid` is 1, the result is `fg_color` with `out_vld` = 1, whatever the background and trimming settings are.
- R4: A dot whose own bit is 0 is an outline candidate when any of the bits at columns col-1, col and col+1 of `row_up` and `row_dn`, or at columns col-1 and col+1 of `row_mid`, is 1. Columns -1 and 12 count as 0, so no neighbour wraps around to the opposite edge of the cell.
- R5: `trim_mode` = 2'b11 enables outlines. The values 2'b00, 2'b01 and 2'b10 draw no outline.
- R6: `trim_policy` gates outlines by `bg_mode`. 2'b00 never draws them. 2'b01 draws them only when `bg_mode` = 2'b00. 2'b10 draws them when `bg_mode` is 2'b00 or 2'b01. 2'b11 always draws them.
- R7: A drawn outline candidate outputs `trim_color` and takes priority over the background.
- R8: A dot that is neither glyph nor drawn outline outputs `bg_color` when `bg_mode` is not 2'b00 and `bg_color` is not 0. The shaded modes 2'b10 and 2'b11 are coloured the same as solid fill 2'b01.
- R9: A dot that resolves to transparent (background off, or `bg_color` = 0) gives `out_vld` = 0 and `out_color` = 0.
- R10: A `col` value of 12 or more gives `out_vld` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | A dot is presented this cycle |
| row_up | input | 12 | Glyph row above the current row |
| row_mid | input | 12 | Glyph row holding the current dot |
| row_dn | input | 12 | Glyph row below the current row |
| col | input | 4 | Column of the current dot, 0 to 11 |
| fg_color | input | 4 | Character colour |
| bg_mode | input | 2 | Character background: none, solid, concave, convex |
| bg_color | input | 4 | Character background colour, 0 is transparent |
| trim_mode | input | 2 | Per-line outline mode, 2'b11 enables |
| trim_policy | input | 2 | Per-line outline policy against the background |
| trim_color | input | 4 | Per-line outline colour |
| out_vld | output | 1 | Result is opaque |
| out_color | output | 4 | Colour code of the result |

## Verification
The hardest cases to reach are the ones at the cell edges. A set bit at column 11 must not make column 0 an outline dot, and the same holds in the other direction. A defect here stays hidden in any stimulus that keeps glyph bits away from the borders. The bench places single set bits in the far column of each row and probes the opposite edge column. It also walks one set bit around all eight neighbour positions of an interior dot. Every combination of policy and background mode is checked, so that a wrong entry in the gating table shows up as a wrong colour.

// File: rtl/osd_outline_pkg.sv
package osd_outline_pkg;
  typedef enum logic [1:0] {
    DK_NONE  = 2'd0,
    DK_BG    = 2'd1,
    DK_TRIM  = 2'd2,
    DK_GLYPH = 2'd3
  } dot_kind_e;

  localparam logic [1:0] TRIM_EIGHT = 2'b11;
  localparam logic [1:0] BGM_NONE   = 2'b00;
  localparam logic [1:0] BGM_SOLID  = 2'b01;
  localparam logic [1:0] POL_OFF    = 2'b00;
  localparam logic [1:0] POL_BARE   = 2'b01;
  localparam logic [1:0] POL_FLAT   = 2'b10;
  localparam logic [1:0] POL_ALWAYS = 2'b11;
endpackage

// File: rtl/osd_nbr_probe.sv
module osd_nbr_probe #(
  parameter int WIDTH = 12,
  parameter int COL_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] row_up,
  input  logic [WIDTH-1:0] row_mid,
  input  logic [WIDTH-1:0] row_dn,
  input  logic [COL_W-1:0] col,
  output logic             in_range,
  output logic             glyph_hit,
  output logic             edge_hit
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(WIDTH - 1);

  // padded rows: index k holds column k-1, columns -1 and WIDTH are zero
  logic [WIDTH+1:0] up_x, mid_x, dn_x;
  logic [WIDTH-1:0] edge_vec;

  assign up_x  = {1'b0, row_up,  1'b0};
  assign mid_x = {1'b0, row_mid, 1'b0};
  assign dn_x  = {1'b0, row_dn,  1'b0};

  for (genvar j = 0; j < WIDTH; j++) begin : g_col
    assign edge_vec[j] = ~row_mid[j] &
                         ((|up_x[j+2:j]) | (|dn_x[j+2:j]) | mid_x[j] | mid_x[j+2]);
  end

  always_comb begin
    in_range  = (col <= LAST_COL);
    glyph_hit = 1'b0;
    edge_hit  = 1'b0;
    if (in_range) begin
      glyph_hit = row_mid[col];
      edge_hit  = edge_vec[col];
    end
  end
endmodule

// File: rtl/osd_trim_gate.sv
module osd_trim_gate
  import osd_outline_pkg::*;
(
  input  logic [1:0] trim_mode,
  input  logic [1:0] trim_policy,
  input  logic [1:0] bg_mode,
  output logic       trim_en
);
  logic policy_ok;

  always_comb begin
    case (trim_policy)
      POL_OFF:    policy_ok = 1'b0;
      POL_BARE:   policy_ok = (bg_mode == BGM_NONE);
      POL_FLAT:   policy_ok = (bg_mode == BGM_NONE) || (bg_mode == BGM_SOLID);
      POL_ALWAYS: policy_ok = 1'b1;
      default:    policy_ok = 1'b0;
    endcase
    trim_en = (trim_mode == TRIM_EIGHT) && policy_ok;
  end
endmodule

// File: rtl/osd_outline_gen.sv
module osd_outline_gen
  import osd_outline_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int CLR_W = 4,
  parameter int COL_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic [WIDTH-1:0] row_up,
  input  logic [WIDTH-1:0] row_mid,
  input  logic [WIDTH-1:0] row_dn,
  input  logic [COL_W-1:0] col,
  input  logic [CLR_W-1:0] fg_color,
  input  logic [1:0]       bg_mode,
  input  logic [CLR_W-1:0] bg_color,
  input  logic [1:0]       trim_mode,
  input  logic [1:0]       trim_policy,
  input  logic [CLR_W-1:0] trim_color,
  output logic             out_vld,
  output logic [CLR_W-1:0] out_color
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(WIDTH - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic in_range, glyph_hit, edge_hit, trim_en;

  osd_nbr_probe #(.WIDTH(WIDTH), .COL_W(COL_W)) u_probe (
    .row_up   (row_up),
    .row_mid  (row_mid),
    .row_dn   (row_dn),
    .col      (col),
    .in_range (in_range),
    .glyph_hit(glyph_hit),
    .edge_hit (edge_hit)
  );

  osd_trim_gate u_gate (
    .trim_mode  (trim_mode),
    .trim_policy(trim_policy),
    .bg_mode    (bg_mode),
    .trim_en    (trim_en)
  );

  dot_kind_e        kind_d;
  logic             vld_d;
  logic [CLR_W-1:0] color_d;

  // next state
  always_comb begin
    kind_d = DK_NONE;
    if (in_range) begin
      if (glyph_hit)                                  kind_d = DK_GLYPH;
      else if (edge_hit && trim_en)                   kind_d = DK_TRIM;
      else if (bg_mode != BGM_NONE && bg_color != '0) kind_d = DK_BG;
    end
    case (kind_d)
      DK_GLYPH: color_d = fg_color;
      DK_TRIM:  color_d = trim_color;
      DK_BG:    color_d = bg_color;
      default:  color_d = '0;
    endcase
    vld_d = pix_vld && (kind_d != DK_NONE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_vld   <= 1'b0;
      out_color <= '0;
    end else begin
      out_vld <= vld_d;
      if (pix_vld) out_color <= color_d;
    end
  end

  // R3
  glyph_wins_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (pix_vld && col <= LAST_COL && row_mid[col]) |=> (out_vld && out_color == $past(fg_color)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !pix_vld |=> (!out_vld && $stable(out_color)));

  // R10
  range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (pix_vld && col > LAST_COL) |=> !out_vld);

  // R5
  no_trim_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (pix_vld && col <= LAST_COL && !row_mid[col] && trim_mode != TRIM_EIGHT && bg_mode == BGM_NONE)
      |=> !out_vld);

  // R9
  clear_bg_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (pix_vld && row_up == '0 && row_mid == '0 && row_dn == '0 && bg_color == '0)
      |=> (!out_vld && out_color == '0));
endmodule

// File: tb/osd_outline_gen_test.sv
module osd_outline_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_vld;
  logic [11:0] row_up, row_mid, row_dn;
  logic [3:0]  col, fg_color, bg_color, trim_color;
  logic [1:0]  bg_mode, trim_mode, trim_policy;
  logic        out_vld;
  logic [3:0]  out_color;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  osd_outline_gen uut (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld),
    .row_up(row_up), .row_mid(row_mid), .row_dn(row_dn), .col(col),
    .fg_color(fg_color), .bg_mode(bg_mode), .bg_color(bg_color),
    .trim_mode(trim_mode), .trim_policy(trim_policy), .trim_color(trim_color),
    .out_vld(out_vld), .out_color(out_color)
  );

  function automatic bit bit_at(logic [11:0] r, int c);
    if (c < 0 || c > 11) return 1'b0;
    return r[c];
  endfunction

  // independent model built from the requirement text
  function automatic logic [4:0] model();
    int  c = int'(col);
    bit  near = 1'b0;
    bit  draw;
    if (c > 11) return 5'd0;
    if (row_mid[c]) return {1'b1, fg_color};
    for (int dx = -1; dx <= 1; dx++) begin
      near |= bit_at(row_up, c + dx) | bit_at(row_dn, c + dx);
      if (dx != 0) near |= bit_at(row_mid, c + dx);
    end
    draw = (trim_mode == 2'b11) &&
           ((trim_policy == 2'b11) ||
            (trim_policy == 2'b01 && bg_mode == 2'b00) ||
            (trim_policy == 2'b10 && bg_mode <= 2'b01));
    if (near && draw) return {1'b1, trim_color};
    if (bg_mode != 2'b00 && bg_color != 4'd0) return {1'b1, bg_color};
    return 5'd0;
  endfunction

  task automatic check(string tag, logic [4:0] exp);
    n_run++;
    if ({out_vld, out_color} !== exp) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b color=%0d, expected vld=%0b color=%0d",
               tag, out_vld, out_color, exp[4], exp[3:0]);
    end
  endtask

  // drive at negedge, result registered at posedge, sampled at the next negedge
  task automatic dot(string tag);
    logic [4:0] exp;
    pix_vld = 1'b1;
    exp = model();
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic set_attr(logic [3:0] fg, logic [1:0] bm, logic [3:0] bc,
                          logic [1:0] tm, logic [1:0] tp, logic [3:0] tc);
    fg_color = fg; bg_mode = bm; bg_color = bc;
    trim_mode = tm; trim_policy = tp; trim_color = tc;
  endtask

  task automatic t_reset();
    pix_vld = 1'b1; row_up = '0; row_mid = 12'hFFF; row_dn = '0; col = 4'd3;
    set_attr(4'd5, 2'b01, 4'd7, 2'b11, 2'b11, 4'd9);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 5'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 5'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_glyph();
    row_up = 12'h0; row_mid = 12'h030; row_dn = 12'h0;
    set_attr(4'd6, 2'b01, 4'd3, 2'b11, 2'b11, 4'd12);
    col = 4'd4; dot("R3 glyph with bg and trim on");
    col = 4'd5; set_attr(4'd15, 2'b11, 4'd0, 2'b00, 2'b00, 4'd1); dot("R3 glyph with all off");
  endtask

  task automatic t_dirs();
    set_attr(4'd2, 2'b00, 4'd0, 2'b11, 2'b11, 4'd11);
    col = 4'd5;
    for (int k = 0; k < 8; k++) begin
      int dx = (k % 3) - 1;
      int dy = (k < 3) ? -1 : ((k < 5) ? 0 : 1);
      if (k == 3) dx = -1;
      if (k == 4) dx = 1;
      if (k >= 5) dx = k - 6;
      row_up = '0; row_mid = '0; row_dn = '0;
      if (dy < 0) row_up[5 + dx] = 1'b1;
      else if (dy > 0) row_dn[5 + dx] = 1'b1;
      else row_mid[5 + dx] = 1'b1;
      dot($sformatf("R4 neighbour dx=%0d dy=%0d", dx, dy));
    end
    row_up = 12'h081; row_mid = 12'h0; row_dn = 12'h801;
    dot("R4 bits two columns away");
  endtask

  task automatic t_edges();
    set_attr(4'd2, 2'b00, 4'd0, 2'b11, 2'b11, 4'd11);
    row_up = 12'h800; row_mid = 12'h800; row_dn = 12'h800;
    col = 4'd0; dot("R4 column 0 no wrap from column 11");
    col = 4'd10; dot("R4 column 10 next to column 11");
    row_up = 12'h001; row_mid = 12'h001; row_dn = 12'h001;
    col = 4'd11; dot("R4 column 11 no wrap from column 0");
    col = 4'd1; dot("R4 column 1 next to column 0");
  endtask

  task automatic t_modes();
    row_up = '0; row_mid = 12'h010; row_dn = '0; col = 4'd3;
    for (int m = 0; m < 4; m++) begin
      set_attr(4'd1, 2'b00, 4'd0, m[1:0], 2'b11, 4'd13);
      dot($sformatf("R5 trim mode %0d", m));
    end
  endtask

  task automatic t_policy();
    row_up = '0; row_mid = 12'h100; row_dn = '0; col = 4'd7;
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 4; b++) begin
        set_attr(4'd1, b[1:0], 4'd6, 2'b11, p[1:0], 4'd14);
        dot($sformatf("R6 R7 policy %0d bg mode %0d", p, b));
      end
  endtask

  task automatic t_background();
    row_up = '0; row_mid = '0; row_dn = '0; col = 4'd2;
    for (int b = 1; b < 4; b++) begin
      set_attr(4'd1, b[1:0], 4'd8, 2'b11, 2'b11, 4'd14);
      dot($sformatf("R8 bg mode %0d", b));
    end
    set_attr(4'd1, 2'b01, 4'd0, 2'b11, 2'b11, 4'd14);
    dot("R9 background code 0 transparent");
    set_attr(4'd1, 2'b00, 4'd9, 2'b11, 2'b11, 4'd14);
    dot("R9 background off");
  endtask

  task automatic t_range();
    row_up = 12'hFFF; row_mid = 12'hFFF; row_dn = 12'hFFF;
    set_attr(4'd4, 2'b01, 4'd5, 2'b11, 2'b11, 4'd6);
    col = 4'd12; dot("R10 column 12");
    col = 4'd15; dot("R10 column 15");
  endtask

  task automatic t_hold();
    row_up = '0; row_mid = 12'h004; row_dn = '0; col = 4'd2;
    set_attr(4'd10, 2'b00, 4'd0, 2'b00, 2'b00, 4'd0);
    dot("R2 glyph before idle");
    pix_vld = 1'b0; fg_color = 4'd3; bg_mode = 2'b01; bg_color = 4'd7;
    @(negedge clk);
    check("R2 idle cycle holds colour", {1'b0, 4'd10});
    @(negedge clk);
    check("R2 second idle cycle", {1'b0, 4'd10});
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_glyph();
    t_dirs();
    t_edges();
    t_modes();
    t_policy();
    t_background();
    t_range();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    finish_run();
  end
endmodule